// File: doc/BRIEF.md
# Pad Deep-Sleep Output Retention Controller

This block sits between the pad output selection logic and the pad ring. While the chip is awake it passes the data and output-enable chosen for each pad straight through. When the global sleep request rises, every pad whose sleep arm bit is set moves into a retained sleep state. From then on it drives a forced value, chosen by its two-bit sleep mode, instead of the awake value.

A pad stays in the retained state until software writes 1 to that pad's sleep status clear input. A falling sleep request does not release it. Two independent pad groups are handled the same way: multiplexed pads and dedicated pads. Each pad is a small two-state machine with states `PAD_AWAKE` and `PAD_ASLEEP`. The transitions are:

- `ENTER`: `PAD_AWAKE` to `PAD_ASLEEP`, on a qualifying rising edge.
- `REARM`: `PAD_ASLEEP` to `PAD_ASLEEP` with a fresh forced value, on a qualifying rising edge.
- `RELEASE`: `PAD_ASLEEP` to `PAD_AWAKE`, on a clear write with no qualifying edge in the same cycle.

Top module: `pad_sleep_hold`

## Requirements
- R1: After reset, every pad is in `PAD_AWAKE`, every status bit reads 0, and the pad outputs equal the awake inputs.
- R2: A pad in `PAD_AWAKE` drives its awake data and awake enable combinationally, in the same cycle.
- R3: A pad enters sleep only on a qualifying rising edge. A qualifying edge is a clock edge where the sleep request is 1, the registered copy of the sleep request from the previous cycle is 0, and the pad's arm bit is 1. A held-high request or an arm bit of 0 causes no entry.
- R4: Sleep mode 2'b00 drives data 0 with enable 1, and sleep mode 2'b01 drives data 1 with enable 1. Both take effect from the cycle after the edge.
- R5: Sleep mode 2'b10 floats the pad: data 0 with enable 0.
- R6: Sleep mode 2'b11 freezes the data and enable that the pad was driving in the cycle of the edge.
- R7: While a pad is asleep and no qualifying edge occurs, its data and enable stay unchanged. This holds when the awake inputs change, when the mode changes and when the sleep request falls.
- R8: A clear input of 1 on a sleeping pad returns it to `PAD_AWAKE` in the next cycle, and its status reads 0.
- R9: If a clear and a qualifying edge occur in the same cycle, entry wins and the status stays 1.
- R10: A qualifying edge on a pad that is already asleep reloads the forced value using the current mode.
- R11: Both pad groups behave identically, and each pad follows only its own arm, mode and clear bits.
- R12: The status bit is 1 exactly while the pad is asleep, and it stays 1 with the sleep request low until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Global sleep request level |
| mux_slp_arm_i | input | NUM_MUX | Per-pad sleep arm bits, multiplexed group |
| mux_slp_mode_i | input | NUM_MUX x 2 | Per-pad sleep mode, multiplexed group |
| mux_slp_clr_i | input | NUM_MUX | Per-pad status clear write strobes, multiplexed group |
| mux_awake_out_i | input | NUM_MUX | Awake pad data, multiplexed group |
| mux_awake_oe_i | input | NUM_MUX | Awake pad enable, multiplexed group |
| mux_pad_out_o | output | NUM_MUX | Final pad data, multiplexed group |
| mux_pad_oe_o | output | NUM_MUX | Final pad enable, multiplexed group |
| mux_slp_stat_o | output | NUM_MUX | Sleep status bits, multiplexed group |
| ded_slp_arm_i | input | NUM_DED | Per-pad sleep arm bits, dedicated group |
| ded_slp_mode_i | input | NUM_DED x 2 | Per-pad sleep mode, dedicated group |
| ded_slp_clr_i | input | NUM_DED | Per-pad status clear write strobes, dedicated group |
| ded_awake_out_i | input | NUM_DED | Awake pad data, dedicated group |
| ded_awake_oe_i | input | NUM_DED | Awake pad enable, dedicated group |
| ded_pad_out_o | output | NUM_DED | Final pad data, dedicated group |
| ded_pad_oe_o | output | NUM_DED | Final pad enable, dedicated group |
| ded_slp_stat_o | output | NUM_DED | Sleep status bits, dedicated group |

## Verification
The bench builds the block with NUM_MUX = 5 and NUM_DED = 3, which differ from the defaults and from each other. A slip in the slice boundaries between the two groups, or a swapped group, therefore shows up at the ports. Eight pads are few enough that random arm, mode and clear patterns often leave some pads asleep and others awake in the same cycle. This makes per-pad independence, re-entry while asleep, and a clear landing in the same cycle as an edge all reachable within a few thousand cycles.

// File: rtl/pad_slp_pkg.sv
package pad_slp_pkg;

    typedef enum logic [1:0] {
        SLP_DRIVE_LOW  = 2'b00,
        SLP_DRIVE_HIGH = 2'b01,
        SLP_FLOAT      = 2'b10,
        SLP_FREEZE     = 2'b11
    } slp_mode_e;

    typedef enum logic {
        PAD_AWAKE  = 1'b0,
        PAD_ASLEEP = 1'b1
    } pad_state_e;

    typedef struct packed {
        logic dat;
        logic en;
    } pad_drv_t;

    // Value a pad takes when sleep is entered, given the drive present at entry.
    function automatic pad_drv_t forced_drive(slp_mode_e mode, pad_drv_t now_drv);
        pad_drv_t r;
        unique case (mode)
            SLP_DRIVE_LOW:  r = '{dat: 1'b0, en: 1'b1};
            SLP_DRIVE_HIGH: r = '{dat: 1'b1, en: 1'b1};
            SLP_FLOAT:      r = '{dat: 1'b0, en: 1'b0};
            SLP_FREEZE:     r = now_drv;
            default:        r = '{dat: 1'b0, en: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slp_edge_detect.sv
module slp_edge_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic rise_o
);

    logic req_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_i;
        end
    end

    assign rise_o = req_i & ~req_q;

endmodule

// File: rtl/pad_hold_cell.sv
module pad_hold_cell
    import pad_slp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rise_i,
    input  logic       arm_i,
    input  logic [1:0] mode_i,
    input  logic       clr_i,
    input  logic       awake_dat_i,
    input  logic       awake_en_i,
    output logic       pad_dat_o,
    output logic       pad_en_o,
    output logic       stat_o
);

    pad_state_e state_q, state_d;
    pad_drv_t   held_q, held_d;
    pad_drv_t   drv_now;
    logic       enter;

    assign enter = rise_i & arm_i;

    // State and held-value register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PAD_AWAKE;
            held_q  <= '{dat: 1'b0, en: 1'b0};
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Transitions: ENTER, REARM, RELEASE.
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            PAD_AWAKE: begin
                if (enter) begin
                    state_d = PAD_ASLEEP;
                    held_d  = forced_drive(slp_mode_e'(mode_i), drv_now);
                end
            end
            PAD_ASLEEP: begin
                if (enter) begin
                    held_d = forced_drive(slp_mode_e'(mode_i), drv_now);
                end else if (clr_i) begin
                    state_d = PAD_AWAKE;
                end
            end
            default: begin
                state_d = PAD_AWAKE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            PAD_ASLEEP: drv_now = held_q;
            default:    drv_now = '{dat: awake_dat_i, en: awake_en_i};
        endcase
        pad_dat_o = drv_now.dat;
        pad_en_o  = drv_now.en;
        stat_o    = (state_q == PAD_ASLEEP);
    end

endmodule

// File: rtl/pad_hold_bank.sv
module pad_hold_bank #(
    parameter int N = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic [N-1:0]     arm_i,
    input  logic [N-1:0][1:0] mode_i,
    input  logic [N-1:0]     clr_i,
    input  logic [N-1:0]     awake_dat_i,
    input  logic [N-1:0]     awake_en_i,
    output logic [N-1:0]     pad_dat_o,
    output logic [N-1:0]     pad_en_o,
    output logic [N-1:0]     stat_o
);

    for (genvar g = 0; g < N; g++) begin : g_pad
        pad_hold_cell u_cell (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .rise_i      (rise_i),
            .arm_i       (arm_i[g]),
            .mode_i      (mode_i[g]),
            .clr_i       (clr_i[g]),
            .awake_dat_i (awake_dat_i[g]),
            .awake_en_i  (awake_en_i[g]),
            .pad_dat_o   (pad_dat_o[g]),
            .pad_en_o    (pad_en_o[g]),
            .stat_o      (stat_o[g])
        );
    end

endmodule

// File: rtl/pad_sleep_hold.sv
module pad_sleep_hold #(
    parameter int NUM_MUX = 8,
    parameter int NUM_DED = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sleep_req_i,
    input  logic [NUM_MUX-1:0]     mux_slp_arm_i,
    input  logic [NUM_MUX-1:0][1:0] mux_slp_mode_i,
    input  logic [NUM_MUX-1:0]     mux_slp_clr_i,
    input  logic [NUM_MUX-1:0]     mux_awake_out_i,
    input  logic [NUM_MUX-1:0]     mux_awake_oe_i,
    output logic [NUM_MUX-1:0]     mux_pad_out_o,
    output logic [NUM_MUX-1:0]     mux_pad_oe_o,
    output logic [NUM_MUX-1:0]     mux_slp_stat_o,
    input  logic [NUM_DED-1:0]     ded_slp_arm_i,
    input  logic [NUM_DED-1:0][1:0] ded_slp_mode_i,
    input  logic [NUM_DED-1:0]     ded_slp_clr_i,
    input  logic [NUM_DED-1:0]     ded_awake_out_i,
    input  logic [NUM_DED-1:0]     ded_awake_oe_i,
    output logic [NUM_DED-1:0]     ded_pad_out_o,
    output logic [NUM_DED-1:0]     ded_pad_oe_o,
    output logic [NUM_DED-1:0]     ded_slp_stat_o
);

    logic sleep_rise;

    // One shared edge detector so both groups see the same entry cycle.
    slp_edge_detect u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (sleep_req_i),
        .rise_o (sleep_rise)
    );

    pad_hold_bank #(.N(NUM_MUX)) u_mux_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rise_i      (sleep_rise),
        .arm_i       (mux_slp_arm_i),
        .mode_i      (mux_slp_mode_i),
        .clr_i       (mux_slp_clr_i),
        .awake_dat_i (mux_awake_out_i),
        .awake_en_i  (mux_awake_oe_i),
        .pad_dat_o   (mux_pad_out_o),
        .pad_en_o    (mux_pad_oe_o),
        .stat_o      (mux_slp_stat_o)
    );

    pad_hold_bank #(.N(NUM_DED)) u_ded_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rise_i      (sleep_rise),
        .arm_i       (ded_slp_arm_i),
        .mode_i      (ded_slp_mode_i),
        .clr_i       (ded_slp_clr_i),
        .awake_dat_i (ded_awake_out_i),
        .awake_en_i  (ded_awake_oe_i),
        .pad_dat_o   (ded_pad_out_o),
        .pad_en_o    (ded_pad_oe_o),
        .stat_o      (ded_slp_stat_o)
    );

endmodule

// File: rtl/pad_slp_chk.sv
module pad_slp_chk #(
    parameter int N = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sleep_req_i,
    input logic [N-1:0]     arm_i,
    input logic [N-1:0][1:0] mode_i,
    input logic [N-1:0]     clr_i,
    input logic [N-1:0]     awake_out_i,
    input logic [N-1:0]     awake_oe_i,
    input logic [N-1:0]     pad_out_i,
    input logic [N-1:0]     pad_oe_i,
    input logic [N-1:0]     stat_i
);

    // Independent copy of the request, used to spot entry edges.
    logic req_seen;
    logic rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_seen <= 1'b0;
        end else begin
            req_seen <= sleep_req_i;
        end
    end

    assign rise = sleep_req_i & ~req_seen;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r2_awake_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !stat_i[i] |-> (pad_out_i[i] == awake_out_i[i] && pad_oe_i[i] == awake_oe_i[i]));

        a_r3_entry_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rise && arm_i[i]) |=> stat_i[i]);

        a_r3_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stat_i[i] && !(rise && arm_i[i])) |=> !stat_i[i]);

        a_r4_mode_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rise && arm_i[i] && mode_i[i] == 2'b00) |=> (!pad_out_i[i] && pad_oe_i[i]));

        a_r4_mode_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rise && arm_i[i] && mode_i[i] == 2'b01) |=> (pad_out_i[i] && pad_oe_i[i]));

        a_r5_mode_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rise && arm_i[i] && mode_i[i] == 2'b10) |=> (!pad_out_i[i] && !pad_oe_i[i]));

        a_r6_mode_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rise && arm_i[i] && mode_i[i] == 2'b11)
            |=> (pad_out_i[i] == $past(pad_out_i[i]) && pad_oe_i[i] == $past(pad_oe_i[i])));

        a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_i[i] && !(rise && arm_i[i]) && !clr_i[i])
            |=> ($stable(pad_out_i[i]) && $stable(pad_oe_i[i])));

        a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_i[i] && clr_i[i] && !(rise && arm_i[i])) |=> !stat_i[i]);

        a_r9_entry_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rise && arm_i[i] && clr_i[i]) |=> stat_i[i]);

        a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_i[i] && !clr_i[i]) |=> stat_i[i]);
    end

endmodule

// R11: the same checker is attached to both pad groups.
bind pad_sleep_hold pad_slp_chk #(.N(NUM_MUX)) u_chk_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .arm_i       (mux_slp_arm_i),
    .mode_i      (mux_slp_mode_i),
    .clr_i       (mux_slp_clr_i),
    .awake_out_i (mux_awake_out_i),
    .awake_oe_i  (mux_awake_oe_i),
    .pad_out_i   (mux_pad_out_o),
    .pad_oe_i    (mux_pad_oe_o),
    .stat_i      (mux_slp_stat_o)
);

bind pad_sleep_hold pad_slp_chk #(.N(NUM_DED)) u_chk_ded (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .arm_i       (ded_slp_arm_i),
    .mode_i      (ded_slp_mode_i),
    .clr_i       (ded_slp_clr_i),
    .awake_out_i (ded_awake_out_i),
    .awake_oe_i  (ded_awake_oe_i),
    .pad_out_i   (ded_pad_out_o),
    .pad_oe_i    (ded_pad_oe_o),
    .stat_i      (ded_slp_stat_o)
);

// File: tb/test_pad_sleep_hold.sv
`timescale 1ns/1ps
module test_pad_sleep_hold;

    localparam int NM = 5;
    localparam int ND = 3;
    localparam int NT = NM + ND;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                 req;
    logic [NT-1:0]        arm, clr, awk_out, awk_oe;
    logic [NT-1:0][1:0]   mode;
    logic [NM-1:0] m_out, m_oe, m_stat;
    logic [ND-1:0] d_out, d_oe, d_stat;
    logic [NT-1:0] out_all, oe_all, stat_all;

    assign out_all  = {d_out, m_out};
    assign oe_all   = {d_oe, m_oe};
    assign stat_all = {d_stat, m_stat};

    pad_sleep_hold #(.NUM_MUX(NM), .NUM_DED(ND)) i_pad_sleep_hold (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .sleep_req_i     (req),
        .mux_slp_arm_i   (arm[NM-1:0]),
        .mux_slp_mode_i  (mode[NM-1:0]),
        .mux_slp_clr_i   (clr[NM-1:0]),
        .mux_awake_out_i (awk_out[NM-1:0]),
        .mux_awake_oe_i  (awk_oe[NM-1:0]),
        .mux_pad_out_o   (m_out),
        .mux_pad_oe_o    (m_oe),
        .mux_slp_stat_o  (m_stat),
        .ded_slp_arm_i   (arm[NT-1:NM]),
        .ded_slp_mode_i  (mode[NT-1:NM]),
        .ded_slp_clr_i   (clr[NT-1:NM]),
        .ded_awake_out_i (awk_out[NT-1:NM]),
        .ded_awake_oe_i  (awk_oe[NT-1:NM]),
        .ded_pad_out_o   (d_out),
        .ded_pad_oe_o    (d_oe),
        .ded_slp_stat_o  (d_stat)
    );

    // Reference model state.
    logic [NT-1:0] md_sleep, md_hdat, md_hen;
    logic          md_prev;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [NT-1:0] exp_dat();
        return (md_sleep & md_hdat) | (~md_sleep & awk_out);
    endfunction

    function automatic logic [NT-1:0] exp_en();
        return (md_sleep & md_hen) | (~md_sleep & awk_oe);
    endfunction

    task automatic model_step();
        logic [NT-1:0] cd, ce;
        logic rise;
        cd = exp_dat();
        ce = exp_en();
        rise = req & ~md_prev;
        for (int i = 0; i < NT; i++) begin
            if (rise && arm[i]) begin
                md_sleep[i] = 1'b1;
                case (mode[i])
                    2'b00:   begin md_hdat[i] = 1'b0;  md_hen[i] = 1'b1;  end
                    2'b01:   begin md_hdat[i] = 1'b1;  md_hen[i] = 1'b1;  end
                    2'b10:   begin md_hdat[i] = 1'b0;  md_hen[i] = 1'b0;  end
                    default: begin md_hdat[i] = cd[i]; md_hen[i] = ce[i]; end
                endcase
            end else if (md_sleep[i] && clr[i]) begin
                md_sleep[i] = 1'b0;
            end
        end
        md_prev = req;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic cmp(string tag, string what, logic [NT-1:0] act, logic [NT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic chk(string tag);
        #1;
        cmp(tag, "data", out_all, exp_dat());
        cmp(tag, "enable", oe_all, exp_en());
        cmp(tag, "status", stat_all, md_sleep);
    endtask

    task automatic rand_awake();
        awk_out = NT'($urandom());
        awk_oe  = NT'($urandom());
    endtask

    task automatic all_modes(logic [1:0] m);
        for (int i = 0; i < NT; i++) mode[i] = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        req = 0; arm = '0; clr = '0; mode = '0; awk_out = '0; awk_oe = '0;
        md_sleep = '0; md_hdat = '0; md_hen = '0; md_prev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rand_awake();
        chk("R1");
        rand_awake();
        chk("R2");

        // R3: edge with no pad armed, then level held high.
        arm = '0; req = 1; tick(); chk("R3");
        arm = '1; tick(); chk("R3");
        req = 0; tick();

        // R4: alternate low and high forced modes.
        for (int i = 0; i < NT; i++) mode[i] = (i % 2 == 0) ? 2'b00 : 2'b01;
        req = 1; tick(); chk("R4");

        // R7: inputs move, request falls, mode changes.
        req = 0; rand_awake(); all_modes(2'b10); tick(); rand_awake(); tick(); chk("R7");

        // R8: clear every pad.
        clr = '1; tick(); chk("R8");
        clr = '0;

        // R5: float.
        all_modes(2'b10); req = 1; tick(); chk("R5");
        req = 0; clr = '1; tick(); clr = '0;

        // R6: freeze the current awake values.
        rand_awake(); all_modes(2'b11); req = 1; tick(); chk("R6");
        rand_awake(); tick(); chk("R6");

        // R10: re-entry while asleep picks up the new mode.
        req = 0; tick();
        all_modes(2'b00); req = 1; tick(); chk("R10");

        // R9: clear and entry edge in the same cycle.
        req = 0; tick();
        req = 1; clr = '1; tick(); chk("R9");
        clr = '0; req = 0;

        // R12: status stays set with the request low.
        repeat (5) tick();
        chk("R12");

        // R11: partial arming across both groups.
        clr = '1; tick(); clr = '0;
        arm = NT'(8'b1010_0110);
        for (int i = 0; i < NT; i++) mode[i] = 2'(i);
        rand_awake(); req = 1; tick(); chk("R11");
        rand_awake(); req = 0; tick(); chk("R11");

        // Random phase.
        for (int n = 0; n < 4000; n++) begin
            req  = ($urandom() % 3) == 0;
            arm  = NT'($urandom());
            clr  = NT'($urandom() & $urandom() & $urandom());
            for (int i = 0; i < NT; i++) mode[i] = 2'($urandom());
            rand_awake();
            tick();
            if (md_sleep != '0) chk("R7");
            else                chk("R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule